// File: doc/BRIEF.md
# Glitchless Clock Switch

This block passes one of two free-running clocks to a single clock output. When the selection changes, the output does not show runt pulses. The path that is being dropped is first turned off while its own clock is low. The output then stays low. The new path turns on only after the new clock's domain has seen that the old path is off, and it too turns on while its clock is low. Each path has its own enable flop. The enable request goes through a short synchronizer clocked on the falling edge of that path's clock, and each request is gated by the other path's enable.

A clock can stop at a DC level. In that case its enable flop can never clear, so the handshake would wait forever. A force input removes this wait: the path that is being dropped is cleared at once, and the new path ignores the dropped path's enable.

Behind the mux sit two further controls, both asynchronous. An output gate parks the output at a chosen level. A power-down input holds the output low and removes both enable requests. The gate should be closed before power-down is entered.

Top module: `clk_switch`

## Requirements
- R1: With the gate open and power-down low, `sel`=0 makes `clk_out` equal `clk_a` and `sel`=1 makes it equal `clk_b`, once the switch has completed.
- R2: A path enable changes only while that path's clock is low, unless reset or force is active. After `sel` changes, `clk_out` stops following the old clock by the third falling edge of the old clock.
- R3: The two path enables are never set together. After the old path is off, `clk_out` follows the new clock by the third falling edge of the new clock.
- R4: While `sel` toggles at arbitrary phases, `clk_out` never shows a high or low pulse shorter than the shortest half period of the two input clocks.
- R5: With `force_sel`=1, a switch completes on the new clock alone, even when the old clock is stopped low or stopped high.
- R6: With `force_sel`=0, a switch away from a stopped clock does not complete, and `clk_out` stays low.
- R7: With `gate_en`=0 and power-down low, `clk_out` equals `gate_lvl` at once, without waiting for any clock edge. With `gate_en`=1, `gate_lvl` has no effect.
- R8: With `pwr_dn`=1, `clk_out` is 0 whatever the gate inputs are. After release, the output comes back on the selected clock through the normal handshake.
- R9: While `rst_n`=0, both enables are clear and `clk_out` is 0 with the gate open. After release with `sel`=0, the `clk_a` path comes up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Input clock selected when `sel`=0 |
| clk_b | input | 1 | Input clock selected when `sel`=1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Source choice: 0 for `clk_a`, 1 for `clk_b` |
| force_sel | input | 1 | 1 completes a switch without the handshake from the dropped clock; hold at 0 from power-up |
| gate_en | input | 1 | 1 passes the muxed clock; 0 parks the output |
| gate_lvl | input | 1 | Level driven while the gate is closed |
| pwr_dn | input | 1 | 1 holds the output low and drops both requests |
| clk_out | output | 1 | Switched and gated clock |

## Verification
A selection change and a closure of the output gate, or a power-down, can fall together: the handshake keeps running behind a closed gate. The stimulus table changes `sel` in the same step that closes the gate, and in the same step that raises power-down. While the gate is closed, `clk_out` must sit at the gate level or at 0. When the gate reopens, it must follow the newly chosen clock and never the old one. Separately, a pulse-width monitor watches repeated selection changes made at shifting phases of both clocks.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

    // Number of selectable sources and default synchronizer depth
    localparam int unsigned NUM_PATHS  = 2;
    localparam int unsigned SYNC_DEPTH = 2;

    // Source selection encoding on the select pin
    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;

    // Controls applied behind the clock mux
    typedef struct packed {
        logic pwr_dn;
        logic gate_en;
        logic gate_lvl;
    } outctl_t;

    // True when path idx is the one the select line asks for
    function automatic logic path_wanted(src_e sel, int unsigned idx);
        return (idx == 0) ? (sel == SRC_A) : (sel == SRC_B);
    endfunction

    // Index of the competing path
    function automatic int unsigned peer_of(int unsigned idx);
        return (idx == 0) ? 1 : 0;
    endfunction

endpackage

// File: rtl/clksw_neg_sync.sv
`timescale 1ns/1ps
// Falling-edge shift synchronizer with asynchronous clear.
module clksw_neg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(negedge clk or posedge clr) begin
                if (clr) shreg <= '0;
                else     shreg <= d;
            end
        end else begin : g_chain
            always_ff @(negedge clk or posedge clr) begin
                if (clr) shreg <= '0;
                else     shreg <= {shreg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/clksw_path.sv
`timescale 1ns/1ps
// One source path: request qualification, enable synchronizer, clock gate.
module clksw_path #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wanted,
    input  logic force_sel,
    input  logic pwr_dn,
    input  logic peer_en,
    output logic en,
    output logic gated_clk
);
    logic req;
    logic clr;

    // Ask for this path only when selected, powered, and the peer is off
    // (or the peer is being forced away).
    always_comb begin
        req = wanted & ~pwr_dn & (force_sel | ~peer_en);
    end

    // Reset, or a forced switch away from this path, drops it at once.
    always_comb begin
        clr = ~rst_n | (force_sel & ~wanted);
    end

    clksw_neg_sync #(.STAGES(STAGES)) u_sync (
        .clk (clk),
        .clr (clr),
        .d   (req),
        .q   (en)
    );

    assign gated_clk = clk & en;
endmodule

// File: rtl/clksw_out_gate.sv
`timescale 1ns/1ps
// Asynchronous output stage behind the mux.
module clksw_out_gate
    import clksw_pkg::*;
(
    input  logic    mux_clk,
    input  outctl_t ctl,
    output logic    out
);
    always_comb begin
        if (ctl.pwr_dn)        out = 1'b0;
        else if (!ctl.gate_en) out = ctl.gate_lvl;
        else                   out = mux_clk;
    end
endmodule

// File: rtl/clk_switch.sv
`timescale 1ns/1ps
module clk_switch
    import clksw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic sel,
    input  logic force_sel,
    input  logic gate_en,
    input  logic gate_lvl,
    input  logic pwr_dn,
    output logic clk_out
);
    logic [NUM_PATHS-1:0] src_clk;
    logic [NUM_PATHS-1:0] path_en;
    logic [NUM_PATHS-1:0] path_clk;
    logic                 mux_clk;
    outctl_t              ctl;
    src_e                 sel_src;

    assign src_clk = {clk_b, clk_a};
    assign sel_src = src_e'(sel);

    generate
        for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
            clksw_path #(.STAGES(SYNC_STAGES)) u_path (
                .clk       (src_clk[g]),
                .rst_n     (rst_n),
                .wanted    (path_wanted(sel_src, g)),
                .force_sel (force_sel),
                .pwr_dn    (pwr_dn),
                .peer_en   (path_en[peer_of(g)]),
                .en        (path_en[g]),
                .gated_clk (path_clk[g])
            );
        end
    endgenerate

    assign mux_clk = |path_clk;

    always_comb begin
        ctl.pwr_dn   = pwr_dn;
        ctl.gate_en  = gate_en;
        ctl.gate_lvl = gate_lvl;
    end

    clksw_out_gate u_gate (
        .mux_clk (mux_clk),
        .ctl     (ctl),
        .out     (clk_out)
    );
endmodule

// File: rtl/clk_switch_chk.sv
`timescale 1ns/1ps
module clk_switch_chk (
    input logic       clk_a,
    input logic       clk_b,
    input logic       rst_n,
    input logic       force_sel,
    input logic       gate_en,
    input logic       gate_lvl,
    input logic       pwr_dn,
    input logic       clk_out,
    input logic [1:0] path_en
);
    // R3: enables are mutually exclusive
    assert_en_exclusive_R3: assert property (@(posedge clk_a) disable iff (!rst_n)
        $onehot0(path_en))
        else $error("R3 both path enables set");

    // R8: power-down holds the output low
    assert_pwrdn_low_R8: assert property (@(posedge clk_a) disable iff (!rst_n)
        pwr_dn |-> !clk_out)
        else $error("R8 output high in power-down");

    // R7: closed gate parks the output at the chosen level
    assert_gate_park_R7: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!gate_en && !pwr_dn) |-> (clk_out == gate_lvl))
        else $error("R7 output not at gate level");

    // R2: each enable moves only in its own clock's low phase
    always @(path_en[0]) begin
        if (rst_n === 1'b1 && force_sel === 1'b0) begin
            assert_a_en_low_phase_R2: assert (clk_a == 1'b0)
                else $error("R2 path A enable moved while clk_a high");
        end
    end

    always @(path_en[1]) begin
        if (rst_n === 1'b1 && force_sel === 1'b0) begin
            assert_b_en_low_phase_R2: assert (clk_b == 1'b0)
                else $error("R2 path B enable moved while clk_b high");
        end
    end
endmodule

bind clk_switch clk_switch_chk u_chk (
    .clk_a     (clk_a),
    .clk_b     (clk_b),
    .rst_n     (rst_n),
    .force_sel (force_sel),
    .gate_en   (gate_en),
    .gate_lvl  (gate_lvl),
    .pwr_dn    (pwr_dn),
    .clk_out   (clk_out),
    .path_en   (path_en)
);

// File: tb/clk_switch_tb.sv
`timescale 1ns/1ps
module clk_switch_tb;
    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_n, sel, force_sel, gate_en, gate_lvl, pwr_dn;
    logic clk_out;
    bit   b_run = 1'b1;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // Pulse width monitor for R4
    bit      mon_on = 1'b0;
    bit      mon_first = 1'b1;
    realtime last_t = 0.0;
    int      viol = 0;

    always #10 clk_a = ~clk_a;          // 50 MHz
    always begin
        #14;
        if (b_run) clk_b = ~clk_b;
    end

    clk_switch u_dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .sel(sel),
        .force_sel(force_sel), .gate_en(gate_en), .gate_lvl(gate_lvl),
        .pwr_dn(pwr_dn), .clk_out(clk_out)
    );

    always @(clk_out) begin
        if (mon_on) begin
            if (!mon_first && (($realtime - last_t) < 9.5)) viol++;
            mon_first = 1'b0;
            last_t = $realtime;
        end
    end

    // Vector bits: [5] sel, [4] gate_en, [3] gate_lvl, [2] pwr_dn,
    // [1:0] expected: 0 follow clk_a, 1 follow clk_b, 2 low, 3 high
    localparam int NV = 12;
    localparam logic [5:0] VEC [NV] = '{
        6'b0_1_0_0_00, 6'b1_1_0_0_01, 6'b0_1_0_0_00, 6'b0_0_1_0_11,
        6'b0_0_0_0_10, 6'b1_0_1_0_11, 6'b1_1_0_0_01, 6'b1_0_1_1_10,
        6'b0_1_0_1_10, 6'b0_1_0_0_00, 6'b1_1_0_0_01, 6'b0_1_1_0_00
    };

    task automatic expect_bit(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic follow(input bit use_b, input string tag);
        for (int k = 0; k < 3; k++) begin
            if (use_b) @(posedge clk_b); else @(posedge clk_a);
            #3 expect_bit(clk_out, 1'b1, tag);
            if (use_b) @(negedge clk_b); else @(negedge clk_a);
            #3 expect_bit(clk_out, 1'b0, tag);
        end
    endtask

    task automatic hold_level(input logic lvl, input string tag);
        for (int k = 0; k < 8; k++) begin
            #7 expect_bit(clk_out, lvl, tag);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sel = 1'b0; force_sel = 1'b0;
        gate_en = 1'b1; gate_lvl = 1'b0; pwr_dn = 1'b0;
        // R9: output low during reset
        #5 hold_level(1'b0, "R9 in reset");
        #40 rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            sel      = VEC[i][5];
            gate_en  = VEC[i][4];
            gate_lvl = VEC[i][3];
            pwr_dn   = VEC[i][2];
            #300;
            case (VEC[i][1:0])
                2'd0: follow(1'b0, "R1 follow clk_a");
                2'd1: follow(1'b1, "R1 follow clk_b");
                2'd2: hold_level(1'b0, VEC[i][2] ? "R8 power-down low" : "R7 gate low");
                default: hold_level(1'b1, "R7 gate high");
            endcase
        end

        // R4: pulse widths across switches at shifting phases
        mon_first = 1'b1;
        mon_on = 1'b1;
        for (int i = 0; i < 8; i++) begin
            #(23 + i * 9);
            sel = ~sel;
            #250;
        end
        mon_on = 1'b0;
        n_run++;
        if (viol != 0) begin
            n_fail++;
            $display("FAIL R4: short pulses got %0d expected 0", viol);
        end

        // R2: old path off by third old-clock falling edge
        @(posedge clk_a);
        #1 sel = 1'b1;
        repeat (3) @(negedge clk_a);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk_a);
            #1 expect_bit(clk_out & ~clk_b, 1'b0, "R2 old clock gone");
        end
        // R3: new clock within three new-clock cycles
        repeat (3) @(negedge clk_b);
        #1 follow(1'b1, "R3 new clock up");

        // R6: stopped clk_b (low), no force: switch must wait low
        @(negedge clk_b);
        #1 b_run = 1'b0;
        sel = 1'b0;
        #300 hold_level(1'b0, "R6 waits on dead clock");
        // R5: force completes it
        force_sel = 1'b1;
        #100 follow(1'b0, "R5 forced from stuck-low");
        force_sel = 1'b0;
        b_run = 1'b1;

        // R5: clk_b stuck high while selected
        sel = 1'b1;
        #300;
        @(posedge clk_b);
        #1 b_run = 1'b0;
        #50;
        force_sel = 1'b1;
        sel = 1'b0;
        #100 follow(1'b0, "R5 forced from stuck-high");
        force_sel = 1'b0;
        b_run = 1'b1;
        #100;

        // R7: asynchronous gate response
        #3;
        gate_lvl = 1'b1; gate_en = 1'b0;
        #1 expect_bit(clk_out, 1'b1, "R7 async park high");
        gate_lvl = 1'b0;
        #1 expect_bit(clk_out, 1'b0, "R7 async park low");
        gate_en = 1'b1;
        #100;

        // R9: mid-run reset, then clk_a path comes back
        #7 rst_n = 1'b0;
        #1 hold_level(1'b0, "R9 mid-run reset");
        sel = 1'b0;
        #5 rst_n = 1'b1;
        repeat (3) @(negedge clk_a);
        #1 follow(1'b0, "R9 clk_a after reset");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule